// File: doc/BRIEF.md
# Direction-Driven XY Rotation Pipeline

This block is the fine-rotation back end of a sine/cosine generator. A coarse stage upstream supplies a starting vector (x, y) that is already close to the wanted (cos, sin) and already carries the gain correction. Alongside it comes a vector of precomputed rotation directions, one bit per remaining micro-rotation. The pipeline applies one shift-and-add micro-rotation per stage. Each stage uses the supplied direction bit as given: there is no angle accumulator and no sign decision anywhere in the datapath.

The micro-rotations begin at a configurable iteration index, 5 by default, and the stage count is also a parameter. The defaults cover iterations 5 to 14. Coordinates travel through the stages as 21-bit two's-complement numbers with 19 fractional bits. The final register rounds them to 16-bit results with 14 fractional bits. The block accepts one sample per clock cycle, and a valid flag travels with each sample. The reset input is asserted asynchronously and released through a two-flop synchronizer.

Top module: `xy_rotator_pipe`

## Requirements
- R1: While reset is active, and after it until the first valid sample emerges, out_valid is 0 and out_cos and out_sin are 0.
- R2: A sample presented with in_valid=1 before rising edge e appears with out_valid=1 right after edge e+STAGES (latency STAGES+1 edges, 11 by default). Exactly one output is produced for each valid input, in order, and the pipeline accepts a new sample every cycle.
- R3: Stage k (k = 0 .. STAGES-1) applies iteration i = FIRST_IDX+k: x' = x - s*(y>>>i) and y' = y + s*(x>>>i). Here s = +1 when in_dir[k] = 1 (counter-clockwise) and s = -1 when in_dir[k] = 0.
- R4: Shifts are arithmetic on 21-bit two's-complement values, so negative coordinates round toward minus infinity in each shifted term.
- R5: Each stage uses the direction bit of its own sample, even when consecutive samples carry different direction vectors.
- R6: The outputs are floor((v + 16) / 32) of the final 21-bit value v, that is, round-half-up from 19 to 14 fractional bits, as 16-bit two's complement.
- R7: A cycle with in_valid=0 produces no output. out_cos and out_sin hold their previous values while out_valid is 0.
- R8: For a start vector (cos a, sin a)/G, where G is the product of sqrt(1+2^-2i) over the applied iterations, the outputs are within 2 LSB of cos and sin of a + sum(s_k*atan(2^-i)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| in_valid | input | 1 | Input sample valid |
| in_x | input | 21 | Starting x, signed, 19 fractional bits |
| in_y | input | 21 | Starting y, signed, 19 fractional bits |
| in_dir | input | STAGES (10) | Direction bits; bit k drives stage k, 1 means counter-clockwise |
| out_valid | output | 1 | Output sample valid |
| out_cos | output | 16 | Rounded x, signed, 14 fractional bits |
| out_sin | output | 16 | Rounded y, signed, 14 fractional bits |

## Verification
The case that is hardest to reach from the ports is a full pipeline in which every stage holds a different sample with a different direction vector. Only that case shows whether a direction bit ever lags or leads its data. The bench streams every one of the 1024 direction patterns back-to-back behind start vectors spread around the whole circle, so every stage sees a new sample and a new bit pattern on every cycle. Every output is checked bit-exactly against an integer model and against a real-valued rotation. A second phase puts idle gaps between samples to exercise the hold behaviour.

// File: rtl/xyr_pkg.sv
package xyr_pkg;
  localparam int DEF_FRAC_W   = 19;
  localparam int DEF_OUT_FRAC = 14;
  localparam int DEF_FIRST    = 5;
  localparam int DEF_STAGES   = 10;

  typedef enum logic {
    ROT_CW  = 1'b0,
    ROT_CCW = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/xyr_stage.sv
module xyr_stage
  import xyr_pkg::*;
#(
  parameter int W     = 21,
  parameter int NDIR  = 10,
  parameter int SEL   = 0,
  parameter int SHIFT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic [NDIR-1:0]     dir_i,
  output logic                valid_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic [NDIR-1:0]     dir_o
);
  localparam logic signed [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1} << SHIFT;

  logic signed [W-1:0] xs, ys, x_n, y_n;
  rot_dir_e            dsel;

  always_comb begin
    dsel = rot_dir_e'(dir_i[SEL]);
    xs   = x_i >>> SHIFT;
    ys   = y_i >>> SHIFT;
    if (dsel == ROT_CCW) begin
      x_n = x_i - ys;
      y_n = y_i + xs;
    end else begin
      x_n = x_i + ys;
      y_n = y_i - xs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      dir_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        x_o   <= x_n;
        y_o   <= y_n;
        dir_o <= dir_i;
      end
    end
  end

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && $stable(x_o) && $stable(y_o)));

  // R3
  ccw_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dir_i[SEL] && x_i >= STEP && y_i < 0) |=> (y_o > $past(y_i)));

  // R3
  cw_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !dir_i[SEL] && x_i >= STEP && y_i > 0) |=> (y_o < $past(y_i)));
endmodule

// File: rtl/xyr_round.sv
module xyr_round #(
  parameter int W    = 21,
  parameter int DROP = 5,
  parameter int OW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] x_o,
  output logic signed [OW-1:0] y_o
);
  localparam logic signed [W-1:0] HALF = {{(W-1){1'b0}}, 1'b1} << (DROP - 1);

  logic signed [W-1:0]  xh, yh;
  logic signed [OW-1:0] x_n, y_n;

  always_comb begin
    xh  = x_i + HALF;
    yh  = y_i + HALF;
    x_n = OW'(xh >>> DROP);
    y_n = OW'(yh >>> DROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        x_o <= x_n;
        y_o <= y_n;
      end
    end
  end

  logic signed [W+1:0] x_up, y_up, x_in_e, y_in_e;
  always_comb begin
    x_up   = {{(W+2-OW-DROP){x_o[OW-1]}}, x_o, {DROP{1'b0}}};
    y_up   = {{(W+2-OW-DROP){y_o[OW-1]}}, y_o, {DROP{1'b0}}};
    x_in_e = {{2{x_i[W-1]}}, x_i};
    y_in_e = {{2{y_i[W-1]}}, y_i};
  end

  // R6
  round_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (($past(x_in_e) - x_up) >= -(2**(DROP-1)) &&
                 ($past(x_in_e) - x_up) <   (2**(DROP-1)) &&
                 ($past(y_in_e) - y_up) >= -(2**(DROP-1)) &&
                 ($past(y_in_e) - y_up) <   (2**(DROP-1))));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && $stable(x_o) && $stable(y_o)));
endmodule

// File: rtl/xy_rotator_pipe.sv
module xy_rotator_pipe
  import xyr_pkg::*;
#(
  parameter int   FRAC_W    = DEF_FRAC_W,
  parameter int   OUT_FRAC  = DEF_OUT_FRAC,
  parameter int   FIRST_IDX = DEF_FIRST,
  parameter int   STAGES    = DEF_STAGES,
  localparam int  XY_W      = FRAC_W + 2,
  localparam int  OUT_W     = OUT_FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [XY_W-1:0]  in_x,
  input  logic signed [XY_W-1:0]  in_y,
  input  logic [STAGES-1:0]       in_dir,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_cos,
  output logic signed [OUT_W-1:0] out_sin
);
  localparam int DROP = FRAC_W - OUT_FRAC;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                   v_c [STAGES+1];
  logic signed [XY_W-1:0] x_c [STAGES+1];
  logic signed [XY_W-1:0] y_c [STAGES+1];
  logic [STAGES-1:0]      d_c [STAGES+1];

  always_comb begin
    v_c[0] = in_valid;
    x_c[0] = in_x;
    y_c[0] = in_y;
    d_c[0] = in_dir;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    xyr_stage #(
      .W    (XY_W),
      .NDIR (STAGES),
      .SEL  (k),
      .SHIFT(FIRST_IDX + k)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .valid_i(v_c[k]),
      .x_i    (x_c[k]),
      .y_i    (y_c[k]),
      .dir_i  (d_c[k]),
      .valid_o(v_c[k+1]),
      .x_o    (x_c[k+1]),
      .y_o    (y_c[k+1]),
      .dir_o  (d_c[k+1])
    );
  end

  xyr_round #(
    .W   (XY_W),
    .DROP(DROP),
    .OW  (OUT_W)
  ) u_round (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .valid_i(v_c[STAGES]),
    .x_i    (x_c[STAGES]),
    .y_i    (y_c[STAGES]),
    .valid_o(out_valid),
    .x_o    (out_cos),
    .y_o    (out_sin)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_cos == '0 && out_sin == '0));

  // R5
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    v_c[1] |-> (d_c[1][0] == $past(in_dir[0])));
endmodule

// File: tb/xy_rotator_pipe_bench.sv
module xy_rotator_pipe_bench;
  localparam int N    = 10;
  localparam int FI   = 5;
  localparam int W    = 21;
  localparam int OW   = 16;
  localparam int LAT  = N + 1;
  localparam real PI  = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [W-1:0] in_x, in_y;
  logic [N-1:0] in_dir;
  logic out_valid;
  logic signed [OW-1:0] out_cos, out_sin;

  always #10 clk = ~clk;

  xy_rotator_pipe u_xy_rotator_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_dir(in_dir), .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
  );

  int  checks = 0;
  int  errors = 0;
  longint cyc = 0;
  bit  armed = 0;
  int  last_c = 0, last_s = 0;
  real gain;

  int     qx[$], qy[$];
  real    qc[$], qs[$];
  longint qt[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int x0, input int y0, input int d,
                                output int ex, output int ey);
    longint x = x0, y = y0, xs, ys;
    for (int k = 0; k < N; k++) begin
      xs = x >>> (FI + k);
      ys = y >>> (FI + k);
      if (d[k]) begin x = x - ys; y = y + xs; end
      else      begin x = x + ys; y = y - xs; end
    end
    ex = int'((x + 16) >>> 5);
    ey = int'((y + 16) >>> 5);
  endfunction

  task automatic drive(input real a, input int d, input bit v);
    int x0, y0, ex, ey;
    real th;
    @(negedge clk);
    x0 = int'($rtoi($floor($cos(a) / gain * 524288.0 + 0.5)));
    y0 = int'($rtoi($floor($sin(a) / gain * 524288.0 + 0.5)));
    in_valid = v;
    in_x     = W'(x0);
    in_y     = W'(y0);
    in_dir   = N'(d);
    if (v) begin
      model(x0, y0, d, ex, ey);
      th = a;
      for (int k = 0; k < N; k++)
        th += (d[k] ? 1.0 : -1.0) * $atan(2.0 ** (-(FI + k)));
      qx.push_back(ex); qy.push_back(ey);
      qc.push_back($cos(th) * 16384.0); qs.push_back($sin(th) * 16384.0);
      qt.push_back(cyc);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (armed) begin
      if (out_valid) begin
        if (qx.size() == 0) chk(1'b0, "R2 unexpected output", 1, 0);
        else begin
          int ex, ey; real rc, rs; longint t;
          ex = qx.pop_front(); ey = qy.pop_front();
          rc = qc.pop_front(); rs = qs.pop_front(); t = qt.pop_front();
          chk(cyc == t + LAT, "R2 latency", cyc - t, LAT);
          chk(int'(out_cos) == ex, "R3 R4 R5 R6 cos", out_cos, ex);
          chk(int'(out_sin) == ey, "R3 R4 R5 R6 sin", out_sin, ey);
          chk(($itor(out_cos) - rc) <= 2.0 && (rc - $itor(out_cos)) <= 2.0,
              "R8 cos accuracy", out_cos, $rtoi(rc));
          chk(($itor(out_sin) - rs) <= 2.0 && (rs - $itor(out_sin)) <= 2.0,
              "R8 sin accuracy", out_sin, $rtoi(rs));
        end
      end else begin
        chk(int'(out_cos) == last_c, "R7 cos hold", out_cos, last_c);
        chk(int'(out_sin) == last_s, "R7 sin hold", out_sin, last_s);
      end
      last_c = int'(out_cos);
      last_s = int'(out_sin);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    gain = 1.0;
    for (int k = 0; k < N; k++) gain *= $sqrt(1.0 + 2.0 ** (-2 * (FI + k)));
    rst_n = 1'b0; in_valid = 1'b1; in_x = 21'sd1000; in_y = 21'sd2000; in_dir = '1;
    repeat (4) @(posedge clk);
    #5;
    // R1: outputs quiet while reset holds, even with in_valid high
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_cos == '0 && out_sin == '0, "R1 data in reset", out_cos, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk(out_valid == 1'b0 && out_cos == '0, "R1 after release", out_valid, 0);
    armed = 1;
    // Back-to-back sweep: angles around the circle, every direction pattern
    for (int j = 0; j < 51; j++)
      for (int d = 0; d < (1 << N); d++)
        drive(-PI + j * 2.0 * PI / 51.0, d, 1'b1);
    // Gapped samples with idle cycles between them (R7)
    for (int j = 0; j < 24; j++) begin
      drive(j * 0.27 - 3.0, (j * 373) & 1023, 1'b1);
      for (int g = 0; g < (j % 4); g++) drive(0.5, 1023, 1'b0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT + 4) @(posedge clk);
    #6;
    // R2: every valid input produced exactly one output
    chk(qx.size() == 0, "R2 outputs outstanding", qx.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule